// File: doc/BRIEF.md
# HI/LO Result-Pair Ordering Hazard Monitor

This block watches a retiring instruction stream, at most one instruction per clock, and checks every access to the paired HI/LO result registers for orderings whose results are unpredictable. Each cycle it receives a valid strobe, a three-bit operation class and the instruction's program counter. It answers in the same cycle with a hazard flag and a one-hot hazard-kind code. It also keeps, for each of the two registers, the time of the last read (move-from), the last write (move-to) and the last arithmetic update (multiply or divide).

Time is counted in instructions, not in clocks. A free-running counter advances only on valid cycles, so bubbles never widen a spacing window. Three rules are evaluated. The split-update rule is kept by a small four-state pair machine. Its states are `PAIR_CLEAN` (no split pending), `PAIR_FRESH` (an arithmetic op has updated both registers and neither has been moved-to since), `PAIR_ONLY_HI` and `PAIR_ONLY_LO` (exactly one of the pair has been rewritten after the op). Its transitions are:

- An arithmetic op takes any state to `PAIR_FRESH`.
- A move-to HI or LO takes `PAIR_FRESH` to the matching `PAIR_ONLY_*` state.
- A move-to of the other register takes a `PAIR_ONLY_*` state back to `PAIR_CLEAN`.
- Every other event keeps the current state.

The two spacing rules compare timestamps, and a rule-set mode input enables them.

Top module: `hilo_hazard_mon`

## Requirements
- R1: After reset, no hazard is reported, `hazard_kind` is 0, and all six history timestamps hold the far-past value 2^TS_W-4 (0xFFFC with defaults).
- R2: The first valid instruction after reset has time 0, and each valid instruction advances time by one. A move-from HI (op 1) or move-from LO (op 2) at time t makes that register's read timestamp equal t from the next cycle.
- R3: A move-to HI (op 3) or move-to LO (op 4) at time t sets that register's write timestamp to t. A multiply (op 5) or divide (op 6) at time t sets the arithmetic timestamp of both registers to t. Op 0 and op 7 record nothing.
- R4: Split-update rule, in every mode: after a multiply or divide, if exactly one of HI/LO has been moved-to since, a move-from of either register raises hazard kind bit 0 (code 3'b001). In that cycle `rule1_op_pc` shows the pc of that arithmetic op, and it is 0 in all other cycles.
- R5: The split clears when the other register is also moved-to. A multiply or divide with no move-to after it gives no split-update hazard on a later read. A new op restarts tracking.
- R6: Legacy mode (`rule_mode`=0): a move-to of a register whose last move-from has an age below 3 instructions raises kind bit 1 (3'b010). An age of 3 or more is clean, and only the same register's read counts.
- R7: Legacy mode: a multiply or divide when either register's last move-from has an age below 3 raises kind bit 2 (3'b100).
- R8: Relaxed mode (`rule_mode`=1): the move-to spacing rule is never raised. The arithmetic spacing rule applies to divide only.
- R9: Modern mode (`rule_mode`=2, and 3 behaves the same): neither spacing rule is raised. Multiply and divide only record timestamps.
- R10: Cycles with `ins_valid` low raise no hazard, change no history and do not advance time, whatever `ins_op` holds.
- R11: `hazard` is high exactly when `hazard_kind` is nonzero, and `hazard_kind` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | A retiring instruction is present |
| ins_op | input | 3 | Operation class: 0 other, 1 MF HI, 2 MF LO, 3 MT HI, 4 MT LO, 5 multiply, 6 divide, 7 other |
| rule_mode | input | 2 | 0 legacy, 1 relaxed, 2/3 modern |
| ins_pc | input | PC_W | Program counter of the instruction |
| hazard | output | 1 | Current instruction violates a rule |
| hazard_kind | output | 3 | One-hot: bit0 split-update, bit1 move-to spacing, bit2 arithmetic spacing |
| rule1_op_pc | output | PC_W | pc of the arithmetic op behind a split-update hazard |
| hi_rd_ts | output | TS_W | Time of last move-from HI |
| hi_wr_ts | output | TS_W | Time of last move-to HI |
| hi_ar_ts | output | TS_W | Time of last arithmetic update of HI |
| lo_rd_ts | output | TS_W | Time of last move-from LO |
| lo_wr_ts | output | TS_W | Time of last move-to LO |
| lo_ar_ts | output | TS_W | Time of last arithmetic update of LO |

## Verification
The spacing rules are driven with read-to-write and read-to-op distances of one, two and three instructions. This separates a window that is one cycle too short or too long from the correct one. Bubbles are placed inside a window to show that time counts instructions, not clocks, and a read of one register followed by a write of the other shows the spacing rule is per register. The same sequences are replayed under all three modes, so that a multiply and a divide, which are treated alike in legacy mode, diverge in relaxed mode. The split-update sequences write one register, then both, then none after an op, which covers every transition of the pair machine.

// File: rtl/hlhaz_pkg.sv
package hlhaz_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_MFHI = 3'd1,
        OP_MFLO = 3'd2,
        OP_MTHI = 3'd3,
        OP_MTLO = 3'd4,
        OP_MUL  = 3'd5,
        OP_DIV  = 3'd6,
        OP_RSVD = 3'd7
    } hl_op_e;

    localparam logic [1:0] MODE_LEGACY  = 2'd0;
    localparam logic [1:0] MODE_RELAXED = 2'd1;

    localparam int KIND_SPLIT = 0;
    localparam int KIND_MTGAP = 1;
    localparam int KIND_ARGAP = 2;
    localparam int KIND_W     = 3;

    localparam int NUM_REGS = 2;
    localparam int REG_HI   = 0;
    localparam int REG_LO   = 1;

    typedef enum logic [1:0] {
        PAIR_CLEAN,
        PAIR_FRESH,
        PAIR_ONLY_HI,
        PAIR_ONLY_LO
    } pair_state_e;

endpackage

// File: rtl/hl_reg_history.sv
module hl_reg_history
    import hlhaz_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int PC_W    = 32,
    parameter int SPACING = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_rd,
    input  logic            rec_wr,
    input  logic            rec_ar,
    input  logic [TS_W-1:0] now,
    input  logic [PC_W-1:0] pc,
    output logic [TS_W-1:0] rd_ts,
    output logic [TS_W-1:0] wr_ts,
    output logic [TS_W-1:0] ar_ts,
    output logic [PC_W-1:0] ar_pc,
    output logic            rd_recent
);

    localparam logic [TS_W-1:0] FAR_PAST = '0 - TS_W'(SPACING + 1);
    localparam logic [TS_W-1:0] WINDOW   = TS_W'(SPACING);

    logic [TS_W-1:0] rd_age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ts <= FAR_PAST;
            wr_ts <= FAR_PAST;
            ar_ts <= FAR_PAST;
            ar_pc <= '0;
        end else begin
            if (rec_rd) rd_ts <= now;
            if (rec_wr) wr_ts <= now;
            if (rec_ar) begin
                ar_ts <= now;
                ar_pc <= pc;
            end
        end
    end

    // modular age keeps the comparison correct across counter wrap
    always_comb begin
        rd_age    = now - rd_ts;
        rd_recent = (rd_age < WINDOW);
    end

    a_r2_read_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rd |=> (rd_ts == $past(now)));

    a_r3_arith_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ar |=> (ar_ts == $past(now)) && (ar_pc == $past(pc)));

    a_r3_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_wr |=> $stable(wr_ts));

endmodule

// File: rtl/hl_split_fsm.sv
module hl_split_fsm
    import hlhaz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_arith,
    input  logic ev_mt_hi,
    input  logic ev_mt_lo,
    output logic split
);

    pair_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PAIR_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ev_arith) begin
            state_d = PAIR_FRESH;
        end else begin
            unique case (state_q)
                PAIR_CLEAN:   state_d = PAIR_CLEAN;
                PAIR_FRESH: begin
                    if (ev_mt_hi)      state_d = PAIR_ONLY_HI;
                    else if (ev_mt_lo) state_d = PAIR_ONLY_LO;
                end
                PAIR_ONLY_HI: if (ev_mt_lo) state_d = PAIR_CLEAN;
                PAIR_ONLY_LO: if (ev_mt_hi) state_d = PAIR_CLEAN;
                default:      state_d = PAIR_CLEAN;
            endcase
        end
    end

    always_comb begin
        split = (state_q == PAIR_ONLY_HI) || (state_q == PAIR_ONLY_LO);
    end

    a_r5_fresh_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arith |=> (state_q == PAIR_FRESH));

    a_r4_one_side_splits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_FRESH && !ev_arith && ev_mt_hi) |=> split);

    a_r5_both_sides_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_ONLY_HI && !ev_arith && ev_mt_lo) |=> !split);

endmodule

// File: rtl/hilo_hazard_mon.sv
module hilo_hazard_mon
    import hlhaz_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int PC_W    = 32,
    parameter int SPACING = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [2:0]      ins_op,
    input  logic [1:0]      rule_mode,
    input  logic [PC_W-1:0] ins_pc,
    output logic            hazard,
    output logic [2:0]      hazard_kind,
    output logic [PC_W-1:0] rule1_op_pc,
    output logic [TS_W-1:0] hi_rd_ts,
    output logic [TS_W-1:0] hi_wr_ts,
    output logic [TS_W-1:0] hi_ar_ts,
    output logic [TS_W-1:0] lo_rd_ts,
    output logic [TS_W-1:0] lo_wr_ts,
    output logic [TS_W-1:0] lo_ar_ts
);

    logic [TS_W-1:0] now;

    logic is_mf, is_mul, is_div, is_arith;
    logic [NUM_REGS-1:0] rec_rd, rec_wr;

    logic [TS_W-1:0] rd_ts [NUM_REGS];
    logic [TS_W-1:0] wr_ts [NUM_REGS];
    logic [TS_W-1:0] ar_ts [NUM_REGS];
    logic [PC_W-1:0] ar_pc [NUM_REGS];
    logic [NUM_REGS-1:0] rd_recent;

    logic split;
    logic mtgap_on, argap_on;
    logic [KIND_W-1:0] kind;

    // instruction-time base: advances on retiring instructions only
    always_ff @(posedge clk) begin
        if (!rst_n)         now <= '0;
        else if (ins_valid) now <= now + 1'b1;
    end

    // operation decode, gated by the strobe
    always_comb begin
        is_mf      = ins_valid && (ins_op == OP_MFHI || ins_op == OP_MFLO);
        is_mul     = ins_valid && (ins_op == OP_MUL);
        is_div     = ins_valid && (ins_op == OP_DIV);
        is_arith   = is_mul || is_div;
        rec_rd[REG_HI] = ins_valid && (ins_op == OP_MFHI);
        rec_rd[REG_LO] = ins_valid && (ins_op == OP_MFLO);
        rec_wr[REG_HI] = ins_valid && (ins_op == OP_MTHI);
        rec_wr[REG_LO] = ins_valid && (ins_op == OP_MTLO);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hist
        hl_reg_history #(
            .TS_W    (TS_W),
            .PC_W    (PC_W),
            .SPACING (SPACING)
        ) u_hist (
            .clk       (clk),
            .rst_n     (rst_n),
            .rec_rd    (rec_rd[r]),
            .rec_wr    (rec_wr[r]),
            .rec_ar    (is_arith),
            .now       (now),
            .pc        (ins_pc),
            .rd_ts     (rd_ts[r]),
            .wr_ts     (wr_ts[r]),
            .ar_ts     (ar_ts[r]),
            .ar_pc     (ar_pc[r]),
            .rd_recent (rd_recent[r])
        );
    end

    hl_split_fsm u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_arith (is_arith),
        .ev_mt_hi (rec_wr[REG_HI]),
        .ev_mt_lo (rec_wr[REG_LO]),
        .split    (split)
    );

    // rule selection by mode
    always_comb begin
        mtgap_on = (rule_mode == MODE_LEGACY);
        argap_on = (rule_mode == MODE_LEGACY && is_arith) ||
                   (rule_mode == MODE_RELAXED && is_div);
    end

    always_comb begin
        kind = '0;
        kind[KIND_SPLIT] = is_mf && split;
        kind[KIND_MTGAP] = mtgap_on &&
                           ((rec_wr[REG_HI] && rd_recent[REG_HI]) ||
                            (rec_wr[REG_LO] && rd_recent[REG_LO]));
        kind[KIND_ARGAP] = argap_on && (|rd_recent);
    end

    always_comb begin
        hazard_kind = kind;
        hazard      = |kind;
        rule1_op_pc = '0;
        if (kind[KIND_SPLIT])
            rule1_op_pc = rec_rd[REG_HI] ? ar_pc[REG_HI] : ar_pc[REG_LO];
        hi_rd_ts = rd_ts[REG_HI];
        hi_wr_ts = wr_ts[REG_HI];
        hi_ar_ts = ar_ts[REG_HI];
        lo_rd_ts = rd_ts[REG_LO];
        lo_wr_ts = wr_ts[REG_LO];
        lo_ar_ts = ar_ts[REG_LO];
    end

    a_r11_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hazard_kind));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> (hazard_kind == '0));

    a_r10_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> $stable(now));

    a_r9_modern_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_mode[1]) |-> !hazard_kind[KIND_MTGAP] && !hazard_kind[KIND_ARGAP]);

    a_r8_relaxed_mul_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_mode == MODE_RELAXED && ins_op == OP_MUL) |-> !hazard_kind[KIND_ARGAP]);

    a_r4_pc_only_on_split: assert property (@(posedge clk) disable iff (!rst_n)
        !hazard_kind[KIND_SPLIT] |-> (rule1_op_pc == '0));

endmodule

// File: tb/hilo_hazard_mon_test.sv
`timescale 1ns/1ps
module hilo_hazard_mon_test;

    localparam int TS_W = 16;
    localparam int PC_W = 32;
    localparam logic [TS_W-1:0] FAR = 16'hFFFC;

    localparam logic [2:0] O_NONE = 3'd0, O_MFHI = 3'd1, O_MFLO = 3'd2,
                           O_MTHI = 3'd3, O_MTLO = 3'd4, O_MUL = 3'd5,
                           O_DIV = 3'd6, O_RSVD = 3'd7;
    localparam logic [2:0] K0 = 3'b000, K_SPLIT = 3'b001,
                           K_MTGAP = 3'b010, K_ARGAP = 3'b100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ins_valid = 1'b0;
    logic [2:0]      ins_op = 3'd0;
    logic [1:0]      rule_mode = 2'd0;
    logic [PC_W-1:0] ins_pc = '0;
    logic            hazard;
    logic [2:0]      hazard_kind;
    logic [PC_W-1:0] rule1_op_pc;
    logic [TS_W-1:0] hi_rd_ts, hi_wr_ts, hi_ar_ts, lo_rd_ts, lo_wr_ts, lo_ar_ts;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    hilo_hazard_mon #(.TS_W(TS_W), .PC_W(PC_W), .SPACING(3)) uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .rule_mode(rule_mode), .ins_pc(ins_pc), .hazard(hazard),
        .hazard_kind(hazard_kind), .rule1_op_pc(rule1_op_pc),
        .hi_rd_ts(hi_rd_ts), .hi_wr_ts(hi_wr_ts), .hi_ar_ts(hi_ar_ts),
        .lo_rd_ts(lo_rd_ts), .lo_wr_ts(lo_wr_ts), .lo_ar_ts(lo_ar_ts)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; ins_valid = 1'b0; ins_op = O_NONE; rule_mode = mode;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // issue one valid instruction; check the same-cycle hazard outputs
    task automatic send(input logic [2:0] op, input logic [31:0] pc,
                        input logic [2:0] exp, input logic [31:0] exp_pc, input string tag);
        @(negedge clk);
        ins_valid = 1'b1; ins_op = op; ins_pc = pc;
        #1;
        check(hazard_kind == exp, tag, hazard_kind, exp);
        check(hazard == (exp != 3'b000), {tag, " R11 flag"}, hazard, exp != 3'b000);
        check(rule1_op_pc == exp_pc, {tag, " R4 pc"}, rule1_op_pc, exp_pc);
        @(posedge clk);
        #1;
        ins_valid = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(2'd0);
        #1;
        check(hazard_kind == K0 && !hazard, "R1 kind", hazard_kind, 0);
        check(hi_rd_ts == FAR && hi_wr_ts == FAR && hi_ar_ts == FAR, "R1 hi ts", hi_rd_ts, FAR);
        check(lo_rd_ts == FAR && lo_wr_ts == FAR && lo_ar_ts == FAR, "R1 lo ts", lo_rd_ts, FAR);
    endtask

    task automatic t_history;
        do_reset(2'd2);
        send(O_NONE, 32'h100, K0, 0, "R3 other");
        check(hi_rd_ts == FAR && lo_wr_ts == FAR, "R3 other no record", hi_rd_ts, FAR);
        send(O_MFHI, 32'h104, K0, 0, "R2 mfhi");
        check(hi_rd_ts == 16'd1, "R2 hi read stamp", hi_rd_ts, 1);
        send(O_MTLO, 32'h108, K0, 0, "R3 mtlo");
        check(lo_wr_ts == 16'd2 && hi_wr_ts == FAR, "R3 lo write stamp", lo_wr_ts, 2);
        send(O_MUL, 32'h10C, K0, 0, "R3 mul");
        check(hi_ar_ts == 16'd3 && lo_ar_ts == 16'd3, "R3 arith stamp", hi_ar_ts, 3);
        send(O_RSVD, 32'h110, K0, 0, "R3 rsvd");
        send(O_MFLO, 32'h114, K0, 0, "R2 mflo");
        check(lo_rd_ts == 16'd5, "R2 lo read stamp", lo_rd_ts, 5);
    endtask

    task automatic t_split;
        do_reset(2'd2);
        send(O_MFLO, 32'h200, K0, 0, "R5 no op yet");
        send(O_MUL, 32'hA00, K0, 0, "R4 mul");
        send(O_MFHI, 32'h204, K0, 0, "R5 fresh read");
        send(O_MTHI, 32'h208, K0, 0, "R4 mthi");
        send(O_MFLO, 32'h20C, K_SPLIT, 32'hA00, "R4 split read lo");
        send(O_MFHI, 32'h210, K_SPLIT, 32'hA00, "R4 split read hi");
        send(O_MTLO, 32'h214, K0, 0, "R5 mtlo");
        send(O_MFHI, 32'h218, K0, 0, "R5 both written");
        send(O_DIV, 32'hB00, K0, 0, "R5 div");
        send(O_MTLO, 32'h21C, K0, 0, "R4 mtlo");
        send(O_MFHI, 32'h220, K_SPLIT, 32'hB00, "R4 split after div");
        do_reset(2'd0);
        send(O_DIV, 32'hC00, K0, 0, "R4 legacy div");
        send(O_MTHI, 32'h300, K0, 0, "R4 legacy mthi");
        send(O_MFLO, 32'h304, K_SPLIT, 32'hC00, "R4 legacy split");
    endtask

    task automatic t_mtgap;
        do_reset(2'd0);
        send(O_MFHI, 32'h400, K0, 0, "R6 mfhi t0");
        send(O_MTHI, 32'h404, K_MTGAP, 0, "R6 age1");
        send(O_NONE, 32'h408, K0, 0, "R6 pad");
        send(O_NONE, 32'h40C, K0, 0, "R6 pad");
        send(O_MFLO, 32'h410, K0, 0, "R6 mflo t4");
        send(O_NONE, 32'h414, K0, 0, "R6 pad");
        send(O_MTLO, 32'h418, K_MTGAP, 0, "R6 age2");
        send(O_MFHI, 32'h41C, K0, 0, "R6 mfhi t7");
        send(O_MTLO, 32'h420, K0, 0, "R6 other reg");
        send(O_NONE, 32'h424, K0, 0, "R6 pad");
        send(O_MTHI, 32'h428, K0, 0, "R6 age3 clean");
    endtask

    task automatic t_argap;
        do_reset(2'd0);
        send(O_MFLO, 32'h500, K0, 0, "R7 mflo t0");
        send(O_MUL, 32'h504, K_ARGAP, 0, "R7 mul age1");
        send(O_MFHI, 32'h508, K0, 0, "R7 mfhi t2");
        send(O_NONE, 32'h50C, K0, 0, "R7 pad");
        send(O_DIV, 32'h510, K_ARGAP, 0, "R7 div age2");
        send(O_DIV, 32'h514, K0, 0, "R7 div age3");
    endtask

    task automatic t_relaxed;
        do_reset(2'd1);
        send(O_MFHI, 32'h600, K0, 0, "R8 mfhi");
        send(O_MTHI, 32'h604, K0, 0, "R8 mt no gap rule");
        send(O_MFLO, 32'h608, K0, 0, "R8 mflo");
        send(O_MUL, 32'h60C, K0, 0, "R8 mul free");
        send(O_DIV, 32'h610, K_ARGAP, 0, "R8 div checked");
    endtask

    task automatic t_modern;
        do_reset(2'd2);
        send(O_MFHI, 32'h700, K0, 0, "R9 mfhi");
        send(O_MTHI, 32'h704, K0, 0, "R9 mt free");
        send(O_MFLO, 32'h708, K0, 0, "R9 mflo");
        send(O_DIV, 32'h70C, K0, 0, "R9 div free");
        send(O_MUL, 32'h710, K0, 0, "R9 mul free");
        check(hi_ar_ts == 16'd4, "R9 mul stamp", hi_ar_ts, 4);
        do_reset(2'd3);
        send(O_MFLO, 32'h720, K0, 0, "R9 mode3 mflo");
        send(O_MTLO, 32'h724, K0, 0, "R9 mode3 mt");
    endtask

    task automatic t_bubbles;
        do_reset(2'd0);
        send(O_MFHI, 32'h800, K0, 0, "R10 mfhi t0");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ins_valid = 1'b0; ins_op = (i % 2 == 0) ? O_MTHI : O_MUL;
            #1;
            check(hazard_kind == K0 && !hazard, "R10 idle no hazard", hazard_kind, 0);
        end
        @(negedge clk);
        #1;
        check(hi_wr_ts == FAR && hi_ar_ts == FAR, "R10 idle no record", hi_wr_ts, FAR);
        send(O_MTHI, 32'h804, K_MTGAP, 0, "R10 bubbles not counted");
        check(hi_wr_ts == 16'd1, "R10 time held", hi_wr_ts, 1);
    endtask

    initial begin
        t_reset();
        t_history();
        t_split();
        t_mtgap();
        t_argap();
        t_relaxed();
        t_modern();
        t_bubbles();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule